// File: doc/BRIEF.md
# Smear-and-Popcount Leading Zero Counter

This block counts the leading zeros of a 32-bit unsigned word: the zero bits above the highest set bit, read from the most significant end. It does not use a priority encoder. First it fills every bit below the highest set bit with ones, using a cascade of shift-and-OR steps with shift distances 1, 2, 4, 8 and 16. Then it counts the ones in that filled word with a tree of masked additions. The result is 32 minus that count.

Operands enter on a valid/ready handshake. `in_ready` is tied high, so the block accepts one operand in every cycle that `in_valid` is asserted. The output side has no back-pressure. The consumer must take each result in the cycle in which `out_valid` is high, because the result is not held back for it. A build-time parameter `PIPE` places an optional register between the smearing half and the counting half. This trades one cycle of latency for a shorter combinational path.

Top module: `lzc_smear_pop`

## Requirements
- R1: For an accepted operand x, `out_count` equals the number of zero bits above the highest set bit of x. Examples: 23 gives 27, 15 gives 28, 1 gives 31, 256 gives 23.
- R2: An operand with a single one at bit position k (k = 0 to 31) gives 31-k.
- R3: An operand with bit 31 set gives 0, whatever its lower bits are.
- R4: The operand 0 gives 32. This needs the full 6-bit result, and must not be 0.
- R5: With PIPE=1, `out_valid` rises two clock edges after the edge at which an operand is accepted. With PIPE=0 it rises one edge after. Each accepted operand produces exactly one `out_valid` cycle.
- R6: `in_ready` is always high. Operands presented on consecutive cycles are all accepted and come out in order, one per cycle.
- R7: A cycle with no valid result has `out_valid` low, and `out_count` keeps its previous value.
- R8: After reset, `out_valid` is 0 and `out_count` is 0.
- R9: The result depends only on the position of the highest set bit. The bits below it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_ready | output | 1 | Always 1; operand accepted when in_valid is high |
| in_data | input | 32 | Operand word |
| out_valid | output | 1 | Result present this cycle |
| out_count | output | 6 | Leading-zero count, 0 to 32 |

## Verification
The latency and hold assertions assume that `in_valid` is driven to a known level in every cycle after reset. They also assume the operand is stable around the clock edge. The bench drives every input on the falling edge and holds `in_valid` low whenever it has no operand, which meets both assumptions. Two instances are driven from the same stimulus, one with PIPE=1 and one with PIPE=0. Each result is compared with a bit-scan reference at the cycle that instance's latency predicts.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  localparam int DATA_W      = 32;
  localparam int SMEAR_STEPS = $clog2(DATA_W);
  localparam int CNT_W       = $clog2(DATA_W) + 1;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;
endpackage

// File: rtl/lzc_smear.sv
module lzc_smear
  import lzc_pkg::*;
(
  input  word_t word_i,
  output word_t filled_o
);
  word_t stage [SMEAR_STEPS+1];

  assign stage[0] = word_i;

  // each step ORs in a copy shifted right by a doubling distance: 1,2,4,8,16
  for (genvar s = 0; s < SMEAR_STEPS; s++) begin : g_step
    assign stage[s+1] = stage[s] | (stage[s] >> (1 << s));
  end

  assign filled_o = stage[SMEAR_STEPS];

  // filled word must be a contiguous run of ones ending at bit 0 (R1)
  always_comb begin
    assert_fill_contig_R1: assert ((filled_o & (filled_o + 1'b1)) == '0);
  end
endmodule

// File: rtl/lzc_popcnt.sv
module lzc_popcnt
  import lzc_pkg::*;
(
  input  word_t word_i,
  output cnt_t  ones_o
);
  word_t pair_sum, nib_sum, byte_sum, acc16, acc32;

  always_comb begin
    pair_sum = word_i - ((word_i >> 1) & 32'h5555_5555);
    nib_sum  = ((pair_sum >> 2) & 32'h3333_3333) + (pair_sum & 32'h3333_3333);
    byte_sum = (nib_sum + (nib_sum >> 4)) & 32'h0f0f_0f0f;
    acc16    = byte_sum + (byte_sum >> 8);
    acc32    = acc16 + (acc16 >> 16);
  end

  // keep six bits so that a full word (32 ones) is distinguishable from zero
  assign ones_o = acc32[CNT_W-1:0];

  always_comb begin
    assert_count_range_R4: assert (ones_o <= cnt_t'(DATA_W));
  end
endmodule

// File: rtl/lzc_smear_pop.sv
module lzc_smear_pop
  import lzc_pkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [5:0]  out_count
);
  localparam int LAT = (PIPE != 0) ? 2 : 1;

  word_t filled;
  word_t cnt_src;
  logic  cnt_vld;
  cnt_t  ones;

  assign in_ready = 1'b1;

  lzc_smear u_smear (
    .word_i   (in_data),
    .filled_o (filled)
  );

  if (PIPE != 0) begin : g_pipe
    word_t mid_word;
    logic  mid_vld;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mid_word <= '0;
        mid_vld  <= 1'b0;
      end else begin
        mid_vld <= in_valid;
        if (in_valid) mid_word <= filled;
      end
    end
    assign cnt_src = mid_word;
    assign cnt_vld = mid_vld;
  end else begin : g_nopipe
    assign cnt_src = filled;
    assign cnt_vld = in_valid;
  end

  lzc_popcnt u_pop (
    .word_i (cnt_src),
    .ones_o (ones)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= cnt_vld;
      if (cnt_vld) out_count <= cnt_t'(DATA_W) - ones;
    end
  end

  // cycles since reset, saturating; keeps $past inside the post-reset window
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_count_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_count <= 6'd32);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && age != 2'd0) |-> $stable(out_count));

  if (LAT == 2) begin : g_chk2
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));
    assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid, 2) && $past(in_data, 2) == '0) |-> out_count == 6'd32);
    assert_msb_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2 && $past(in_valid, 2) && $past(in_data[31], 2)) |-> out_count == 6'd0);
  end else begin : g_chk1
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1) |-> (out_valid == $past(in_valid)));
    assert_zero_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && $past(in_valid) && $past(in_data) == '0) |-> out_count == 6'd32);
    assert_msb_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd1 && $past(in_valid) && $past(in_data[31])) |-> out_count == 6'd0);
  end
endmodule

// File: tb/lzc_smear_pop_tb_top.sv
module lzc_smear_pop_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic rdy1, rdy0, v1, v0;
  logic [5:0] c1, c0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lzc_smear_pop #(.PIPE(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_data(in_data), .out_valid(v1), .out_count(c1));

  lzc_smear_pop #(.PIPE(0)) dut0_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0),
    .in_data(in_data), .out_valid(v0), .out_count(c0));

  function automatic int ref_clz(input logic [31:0] x);
    for (int i = 31; i >= 0; i--) if (x[i]) return 31 - i;
    return 32;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one isolated operand; checks both instances at their own latency
  task automatic run_one(input string tag, input logic [31:0] x, input int exp);
    int hold0;
    @(negedge clk);
    in_valid = 1'b1; in_data = x;
    check({tag, " ready"}, int'(rdy1 & rdy0), 1);
    @(negedge clk);
    in_valid = 1'b0; in_data = ~x;
    check({tag, " R5 pipe0 valid"}, int'(v0), 1);
    check({tag, " pipe0 count"}, int'(c0), exp);
    hold0 = int'(c0);
    @(negedge clk);
    check({tag, " R5 pipe1 valid"}, int'(v1), 1);
    check({tag, " pipe1 count"}, int'(c1), exp);
    check({tag, " R7 pipe0 idle"}, int'(v0), 0);
    check({tag, " R7 pipe0 hold"}, int'(c0), hold0);
    @(negedge clk);
    check({tag, " R7 pipe1 idle"}, int'(v1), 0);
    check({tag, " R7 pipe1 hold"}, int'(c1), exp);
  endtask

  task automatic test_reset();
    check("R8 pipe1 valid", int'(v1), 0);
    check("R8 pipe1 count", int'(c1), 0);
    check("R8 pipe0 valid", int'(v0), 0);
    check("R8 pipe0 count", int'(c0), 0);
  endtask

  task automatic test_examples();
    run_one("R1 x=23", 32'd23, 27);
    run_one("R1 x=15", 32'd15, 28);
    run_one("R1 x=1", 32'd1, 31);
    run_one("R1 x=256", 32'd256, 23);
  endtask

  task automatic test_single_bits();
    for (int k = 0; k < 32; k++) run_one($sformatf("R2 bit%0d", k), 32'd1 << k, 31 - k);
  endtask

  task automatic test_msb();
    run_one("R3 msb only", 32'h8000_0000, 0);
    run_one("R3 all ones", 32'hffff_ffff, 0);
    run_one("R3 msb+random", 32'h8000_0000 | $urandom, 0);
  endtask

  task automatic test_zero();
    run_one("R4 zero", 32'h0, 32);
    run_one("R4 zero after ones", 32'h0, 32);
  endtask

  task automatic test_low_bits();
    for (int k = 1; k < 31; k += 3) begin
      logic [31:0] x;
      x = (32'd1 << k) | ($urandom & ((32'd1 << k) - 1));
      run_one($sformatf("R9 top%0d", k), x, 31 - k);
    end
  endtask

  // back-to-back stream: one operand per cycle, results in order
  task automatic test_stream(input int n);
    logic [31:0] vals [16];
    for (int i = 0; i < n; i++) vals[i] = $urandom >> ($urandom % 32);
    vals[0] = 32'h0;
    for (int i = 0; i <= n + 1; i++) begin
      @(negedge clk);
      if (i >= 1 && i <= n) begin
        check($sformatf("R6 pipe0 v%0d", i-1), int'(v0), 1);
        check($sformatf("R6 pipe0 c%0d", i-1), int'(c0), ref_clz(vals[i-1]));
      end
      if (i >= 2) begin
        check($sformatf("R6 pipe1 v%0d", i-2), int'(v1), 1);
        check($sformatf("R6 pipe1 c%0d", i-2), int'(c1), ref_clz(vals[i-2]));
      end
      if (i < n) begin
        check("R6 ready", int'(rdy1 & rdy0), 1);
        in_valid = 1'b1; in_data = vals[i];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R6 R5 pipe1 after stream", int'(v1), 0);
  endtask

  task automatic test_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] x;
      x = $urandom >> ($urandom % 33);
      run_one($sformatf("R1 rand%0d", i), x, ref_clz(x));
    end
  endtask

  initial begin
    void'($urandom(17));
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_examples();
    test_single_bits();
    test_msb();
    test_zero();
    test_low_bits();
    test_stream(12);
    test_random(60);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule